// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block gathers error events from two receive channels and a loss-of-lock indication from a clock PLL. Each event lands in a sticky status bit. A status bit stays set until software writes a 1 to its position. Each status bit has its own enable bit, and a global enable decides whether the interrupt pin is driven at all. The block sits behind a serial register front end, which is not part of this project. It sees that front end only as a plain address/data port with 8-bit registers.

Event inputs are single-cycle pulses from detector logic that lives elsewhere. Nothing flows through the block as a stream, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.
- A write is taken on every rising edge where `reg_we` is high.
- Read data is a combinational function of `reg_addr`.
- The interrupt pad is shown as an output enable plus a level. The pad cell floats the pin whenever the enable is low.

The register map is:

| Address | Contents |
|---|---|
| 0 | Global enable, bit 0 |
| 1 | Channel A enable mask |
| 2 | Channel B enable mask |
| 3 | Channel A status |
| 4 | Channel B status |

Top module: `evt_irq_hub`

## Requirements
- R1: A pulse on `ch_a_evt[i]` or `ch_b_evt[i]` (i = 0..5) sets bit i+2 of that channel's status register on the next clock edge. Bit 7 is the sync error and bit 2 is the start-of-transmission leader error.
- R2: A status bit stays set until a register write puts a 1 on that bit position. Writing 0 to a set status bit leaves it set.
- R3: `pll_lock` passes through a two-flop synchronizer. A high-to-low transition sets bit 0 of channel A status three clock edges after the input changes. A lock input that simply stays low does not set the bit again after it has been cleared, and neither does a rise of the lock input.
- R4: After reset, channel A status reads 0x01, channel B status reads 0x00, and both masks and the global enable read 0.
- R5: Each mask bit sits at the same position as the status bit it enables. Masks are read/write.
- R6: While global enable bit 0 is 0, `irq_oe` is low, so the pin floats.
- R7: While global enable is 1, `irq_oe` is high. `irq_o` is 1 exactly when some status bit and its mask bit are both 1, and 0 otherwise.
- R8: If an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R9: Unimplemented positions read 0 and ignore writes:
  - bit 1 of channel A status and mask;
  - bits 1:0 of channel B status and mask;
  - bits 7:1 of the global enable;
  - addresses 5 to 7.
- R10: Register writes take effect at the rising edge where `reg_we` is high. Reads are combinational and return the register at the addressed location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| ch_a_evt | input | 6 | Channel A event pulses, bit 5 sync error down to bit 0 leader error |
| ch_b_evt | input | 6 | Channel B event pulses, same order |
| pll_lock | input | 1 | PLL lock level, asynchronous |
| irq_oe | output | 1 | Interrupt pad output enable |
| irq_o | output | 1 | Interrupt level while enabled |

## Verification
The assertions check the following on every cycle:
- status bits never drop without a matching write-1;
- an event always wins over a clear in the same cycle;
- bit 0 of channel A status only rises after a detected loss of lock;
- the pad enable drops after the global enable is written to 0;
- unimplemented read positions stay at zero.

Some behaviour only the bench scenarios can show:
- which event input maps to which bit;
- the three-edge latency of the lock path;
- that a steady low lock level does not set the bit again;
- the full status-by-mask sweep behind the interrupt level.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_GLB   = 3'd0,
    RA_MSK_A = 3'd1,
    RA_MSK_B = 3'd2,
    RA_STS_A = 3'd3,
    RA_STS_B = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irqh_sync2.sv
module irqh_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/irqh_lock_mon.sv
module irqh_lock_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic loss_o
);
  logic lock_s;
  logic lock_prev;

  irqh_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lock_i),
    .q_o   (lock_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) lock_prev <= 1'b0;
    else        lock_prev <= lock_s;
  end

  // falling edge of the synchronized lock level
  assign loss_o = lock_prev & ~lock_s;

  AST_LOSS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    loss_o |=> !loss_o); // R3
endmodule

// File: rtl/irqh_stat_reg.sv
module irqh_stat_reg #(
  parameter int         W       = 8,
  parameter logic [W-1:0] IMPL    = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= RST_VAL[i];
        else        bit_q <= set_i[i] | (bit_q & ~clr_i[i]);
      end
      assign q_o[i] = bit_q;
    end else begin : g_none
      assign q_o[i] = 1'b0;
    end
  end

  AST_STICKY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((($past(q_o) & ~$past(clr_i)) & ~q_o) == '0)); // R2
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(set_i) & IMPL & ~q_o) == '0)); // R8
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub #(
  parameter int REG_W = 8,
  parameter int EVT_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [irqh_pkg::ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  input  logic [EVT_W-1:0]           ch_a_evt,
  input  logic [EVT_W-1:0]           ch_b_evt,
  input  logic                       pll_lock,
  output logic                       irq_oe,
  output logic                       irq_o
);
  import irqh_pkg::*;

  localparam int EVT_LSB = REG_W - EVT_W;
  localparam logic [REG_W-1:0] IMPL_A = {{EVT_W{1'b1}}, {(EVT_LSB-1){1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] IMPL_B = {{EVT_W{1'b1}}, {EVT_LSB{1'b0}}};
  localparam logic [REG_W-1:0] RST_A  = {{(REG_W-1){1'b0}}, 1'b1};

  logic             lock_loss;
  logic [REG_W-1:0] set_a, set_b, clr_a, clr_b;
  logic [REG_W-1:0] sts_a, sts_b;
  logic [REG_W-1:0] msk_a, msk_b;
  logic             glb_en;

  irqh_lock_mon u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock_i (pll_lock),
    .loss_o (lock_loss)
  );

  assign set_a = {ch_a_evt, {(EVT_LSB-1){1'b0}}, lock_loss};
  assign set_b = {ch_b_evt, {EVT_LSB{1'b0}}};
  assign clr_a = (reg_we && reg_addr == RA_STS_A) ? reg_wdata : '0;
  assign clr_b = (reg_we && reg_addr == RA_STS_B) ? reg_wdata : '0;

  irqh_stat_reg #(.W(REG_W), .IMPL(IMPL_A), .RST_VAL(RST_A)) u_sts_a (
    .clk (clk), .rst_n (rst_n), .set_i (set_a), .clr_i (clr_a), .q_o (sts_a)
  );

  irqh_stat_reg #(.W(REG_W), .IMPL(IMPL_B), .RST_VAL('0)) u_sts_b (
    .clk (clk), .rst_n (rst_n), .set_i (set_b), .clr_i (clr_b), .q_o (sts_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk_a  <= '0;
      msk_b  <= '0;
      glb_en <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_GLB:   glb_en <= reg_wdata[0];
        RA_MSK_A: msk_a  <= reg_wdata & IMPL_A;
        RA_MSK_B: msk_b  <= reg_wdata & IMPL_B;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RA_GLB:   reg_rdata = {{(REG_W-1){1'b0}}, glb_en};
      RA_MSK_A: reg_rdata = msk_a;
      RA_MSK_B: reg_rdata = msk_b;
      RA_STS_A: reg_rdata = sts_a;
      RA_STS_B: reg_rdata = sts_b;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_oe = glb_en;
  assign irq_o  = glb_en & (|((sts_a & msk_a) | (sts_b & msk_b)));

  always_comb begin
    if (reg_addr == RA_STS_B)
      AST_UNIMPL_B_ZERO: assert (reg_rdata[EVT_LSB-1:0] == '0); // R9
    if (reg_addr > RA_STS_B)
      AST_HOLE_ADDR_ZERO: assert (reg_rdata == '0); // R9
  end

  AST_UNLOCK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_a[0]) |-> $past(lock_loss)); // R3
  AST_PIN_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_GLB && !reg_wdata[0]) |=> !irq_oe); // R6
endmodule

// File: tb/sim_evt_irq_hub.sv
module sim_evt_irq_hub;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] ch_a_evt = '0;
  logic [5:0] ch_b_evt = '0;
  logic       pll_lock = 1'b1;
  logic       irq_oe, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_irq_hub u0 (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .ch_a_evt (ch_a_evt),
    .ch_b_evt (ch_b_evt), .pll_lock (pll_lock), .irq_oe (irq_oe), .irq_o (irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int ch, input logic [5:0] bits);
    @(negedge clk);
    if (ch == 0) ch_a_evt = bits; else ch_b_evt = bits;
    @(negedge clk);
    ch_a_evt = '0; ch_b_evt = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R10: reset values by address
    rd(3'd0, v); chk("R4 glb", v, 8'h00);
    rd(3'd1, v); chk("R4 mask A", v, 8'h00);
    rd(3'd2, v); chk("R4 mask B", v, 8'h00);
    rd(3'd3, v); chk("R4 status A", v, 8'h01);
    rd(3'd4, v); chk("R4 status B", v, 8'h00);
    chk("R6 oe after reset", {7'd0, irq_oe}, 8'h00);

    // R9: holes
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); chk("R9 hole addr", v, 8'h00);
    end
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R5 R9 mask A", v, 8'hFD);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R5 R9 mask B", v, 8'hFC);
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R9 glb", v, 8'h01);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R9 hole write", v, 8'h00);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);

    // R2: clear the reset-set PLL bit
    wr(3'd3, 8'h01); rd(3'd3, v); chk("R2 clear pll bit", v, 8'h00);

    // R1 / R2 sweep over both channels and every event bit
    for (int ch = 0; ch < 2; ch++) begin
      for (int i = 0; i < 6; i++) begin
        logic [7:0] bitv;
        logic [2:0] sa;
        bitv = 8'(1 << (i + 2));
        sa = (ch == 0) ? 3'd3 : 3'd4;
        pulse(ch, 6'(1 << i));
        rd(sa, v); chk("R1 event sets bit", v, bitv);
        rd((ch == 0) ? 3'd4 : 3'd3, v); chk("R1 other channel clean", v, 8'h00);
        wr(sa, 8'h00); rd(sa, v); chk("R2 write 0 keeps", v, bitv);
        wr(sa, ~bitv); rd(sa, v); chk("R2 other ones keep", v, bitv);
        wr(sa, bitv); rd(sa, v); chk("R2 write 1 clears", v, 8'h00);
      end
    end

    // R7 sweep: status bit x mask bit, both channels
    wr(3'd0, 8'h01);
    for (int cs = 0; cs < 2; cs++) begin
      for (int cm = 0; cm < 2; cm++) begin
        for (int j = 0; j < 6; j++) begin
          for (int m = 0; m < 6; m++) begin
            wr(3'd1, (cm == 0) ? 8'(1 << (m + 2)) : 8'h00);
            wr(3'd2, (cm == 1) ? 8'(1 << (m + 2)) : 8'h00);
            pulse(cs, 6'(1 << j));
            chk("R7 oe", {7'd0, irq_oe}, 8'h01);
            chk("R7 irq level", {7'd0, irq_o},
                {7'd0, (cs == cm) && (j == m)});
            wr(3'd3, 8'hFC); wr(3'd4, 8'hFC);
          end
        end
      end
    end
    chk("R7 low when none set", {7'd0, irq_o}, 8'h00);

    // R6: enabled event present but global enable off
    wr(3'd1, 8'h80); pulse(0, 6'h20);
    chk("R7 pre R6 irq high", {7'd0, irq_o}, 8'h01);
    wr(3'd0, 8'h00);
    chk("R6 oe low", {7'd0, irq_oe}, 8'h00);
    wr(3'd3, 8'h80);

    // R8: event and clear in same cycle
    pulse(1, 6'h04);
    @(negedge clk);
    ch_b_evt = 6'h04; reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h10;
    @(negedge clk);
    ch_b_evt = '0; reg_we = 1'b0;
    rd(3'd4, v); chk("R8 set wins", v, 8'h10);
    wr(3'd4, 8'h10); rd(3'd4, v); chk("R8 then clears", v, 8'h00);

    // R3: lock loss edge, latency, level does not retrigger
    wr(3'd1, 8'h01); wr(3'd0, 8'h01);
    @(negedge clk); pll_lock = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(3'd3, v); chk("R3 not yet", v, 8'h00);
    @(negedge clk);
    rd(3'd3, v); chk("R3 set after 3 edges", v, 8'h01);
    chk("R3 R7 irq from pll", {7'd0, irq_o}, 8'h01);
    wr(3'd3, 8'h01);
    repeat (6) @(negedge clk);
    rd(3'd3, v); chk("R3 low level no retrigger", v, 8'h00);
    pll_lock = 1'b1;
    repeat (6) @(negedge clk);
    rd(3'd3, v); chk("R3 rise ignored", v, 8'h00);
    pll_lock = 1'b0;
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk("R3 second loss", v, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule